// File: doc/BRIEF.md
# Debug Arm, Trigger and Breakpoint Controller

This block is the control core of an on-chip debug unit. A host processor writes one 8-bit control word that arms the debugger and picks how a session ends: which processors (the main CPU, the coprocessor, both or neither) get a breakpoint request, and whether that request means entering background debug or taking a software interrupt. The word can also force an immediate trigger. It also selects which comparator bank and which state-control register appear in the debug unit's register window.

The block listens to a state sequencer and a trace unit. The sequencer reports when it reaches its final state. The trace unit reports when a trace session completes. The block tells the sequencer, through single-cycle pulses, when to enter its first state and when to jump to its final state. With tracing off, a final-state hit raises the breakpoint at once. With tracing on, the breakpoint waits for trace completion. Either way the session ends and the block disarms itself.

A coprocessor software-breakpoint request can be passed on to the CPU under its own enable bit. While the block is armed, the configuration fields are locked. All outputs are registered: a response appears one clock after the input that causes it.

Top module: `dbg_arm_ctrl`

## Requirements
- R1: After reset, the control word reads 0x00 and every output is 0.
- R2: The control word layout is as follows. Bit 7 is the arm bit. Bit 6 is the trigger bit. Bit 5 is the coprocessor-breakpoint forward enable. Bit 4 is the background-mode select, driven on `bdm_sel`. Bits 3:2 are the target field. Bits 1:0 are the bank select, driven on `bank_sel`. A read returns the stored word with bit 6 always 0.
- R3: A write with bit 7 = 1 while disarmed sets the arm bit and gives a one-cycle `enter_st1` pulse. A write with bit 7 = 1 while already armed gives no pulse.
- R4: While armed, a write changes only the arm bit. Bits 5:0 keep their values. A write with bit 7 = 0 disarms the block.
- R5: While armed, a write with bits 7 and 6 both 1 gives a one-cycle `force_final` pulse. A write with bit 6 = 0 gives none.
- R6: While `secure` is 1, a trigger write gives no `force_final` pulse.
- R7: A trigger write while disarmed is ignored and gives no `force_final` pulse.
- R8: While armed and `trace_en` = 0, a `final_hit` raises the breakpoint pulses at once and clears the arm bit. The target field selects them: 00 none, 01 `cop_brk`, 10 `cpu_brk`, 11 both. While disarmed, `final_hit` does nothing.
- R9: While armed and `trace_en` = 1, a `final_hit` raises no breakpoint and leaves the block armed. A later `trace_done` raises the pulses selected by the target field and clears the arm bit.
- R10: A `cop_swbrk_req` gives a `cpu_brk` pulse exactly when bit 5 is 1. This holds armed or not and whatever the target field. It never raises `cop_brk`.
- R11: When a session ends in the same cycle as a register write, the block ends disarmed. No `enter_st1` or `force_final` pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control-word write strobe |
| ctl_wdata | input | 8 | Control-word write data |
| ctl_rdata | output | 8 | Control-word read data |
| final_hit | input | 1 | Sequencer reached final state (pulse) |
| trace_done | input | 1 | Trace session completed (pulse) |
| trace_en | input | 1 | Tracing enabled for this session |
| secure | input | 1 | Secure mode, blocks the trigger |
| cop_swbrk_req | input | 1 | Coprocessor software-breakpoint request (pulse) |
| armed | output | 1 | Arm level |
| enter_st1 | output | 1 | Sequencer enter-first-state pulse |
| force_final | output | 1 | Sequencer force-final-state pulse |
| cpu_brk | output | 1 | CPU breakpoint request pulse |
| cop_brk | output | 1 | Coprocessor breakpoint request pulse |
| bdm_sel | output | 1 | 1: background debug, 0: software interrupt |
| bank_sel | output | 2 | Comparator bank / state-control register select |

## Verification
The block has a fixed 8-bit layout and no tunable parameters, so the bench builds the one configuration. Because the word is only eight bits wide, the bench can drive every write value. It sweeps all 256 values from the disarmed state. It then sweeps all 256 values against several locked configurations, with secure mode both off and on. It also steps through every pairing of target code and trace mode, every forward-enable and target pairing for the coprocessor request, and the collision of a session end with a write.

// File: rtl/dbgctl_pkg.sv
package dbgctl_pkg;
  localparam int CTRL_W   = 8;
  localparam int ARM_BIT  = 7;
  localparam int TRIG_BIT = 6;
  localparam int TGT_W    = 2;
  localparam int BANK_W   = 2;
  localparam int CFG_W    = 6;
  localparam int TGT_COP  = 0;
  localparam int TGT_CPU  = 1;

  typedef struct packed {
    logic              fwd_en;
    logic              bdm;
    logic [TGT_W-1:0]  tgt;
    logic [BANK_W-1:0] bank;
  } cfg_t;

  function automatic cfg_t cfg_from_word(input logic [CTRL_W-1:0] w);
    return cfg_t'(w[CFG_W-1:0]);
  endfunction

  function automatic logic [CTRL_W-1:0] word_from_state(input logic arm, input cfg_t c);
    return {arm, 1'b0, c};
  endfunction

  function automatic logic is_trig_write(input logic wr, input logic [CTRL_W-1:0] w);
    return wr && w[ARM_BIT] && w[TRIG_BIT];
  endfunction
endpackage

// File: rtl/dbgctl_regs.sv
module dbgctl_regs
  import dbgctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              session_end,
  output logic              armed,
  output cfg_t              cfg,
  output logic              enter_st1,
  output logic [CTRL_W-1:0] rdata
);
  logic arm_d;
  cfg_t cfg_d;
  logic enter_d;

  always_comb begin
    arm_d = armed;
    if (wr) arm_d = wdata[ARM_BIT];
    if (session_end) arm_d = 1'b0;
  end

  always_comb begin
    cfg_d = cfg;
    if (wr && !armed) cfg_d = cfg_from_word(wdata);
  end

  assign enter_d = wr && wdata[ARM_BIT] && !armed && !session_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      cfg       <= '0;
      enter_st1 <= 1'b0;
    end else begin
      armed     <= arm_d;
      cfg       <= cfg_d;
      enter_st1 <= enter_d;
    end
  end

  assign rdata = word_from_state(armed, cfg);
endmodule

// File: rtl/dbgctl_trig.sv
module dbgctl_trig
  import dbgctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              armed,
  input  logic              secure,
  input  logic              session_end,
  output logic              force_final
);
  logic trig_ok;

  assign trig_ok = is_trig_write(wr, wdata) && armed && !secure && !session_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) force_final <= 1'b0;
    else        force_final <= trig_ok;
  end
endmodule

// File: rtl/dbgctl_brk.sv
module dbgctl_brk
  import dbgctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  cfg_t             cfg,
  input  logic             final_hit,
  input  logic             trace_done,
  input  logic             trace_en,
  input  logic             cop_swbrk_req,
  output logic             session_end,
  output logic [TGT_W-1:0] brk_q
);
  logic sw_fwd;

  assign session_end = armed && ((final_hit && !trace_en) || trace_done);
  assign sw_fwd      = cop_swbrk_req && cfg.fwd_en;

  for (genvar t = 0; t < TGT_W; t++) begin : g_tgt
    logic req_d;
    if (t == TGT_CPU) begin : g_cpu
      assign req_d = (session_end && cfg.tgt[t]) || sw_fwd;
    end else begin : g_other
      assign req_d = session_end && cfg.tgt[t];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) brk_q[t] <= 1'b0;
      else        brk_q[t] <= req_d;
    end
  end
endmodule

// File: rtl/dbg_arm_ctrl.sv
module dbg_arm_ctrl
  import dbgctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic [7:0]  ctl_wdata,
  output logic [7:0]  ctl_rdata,
  input  logic        final_hit,
  input  logic        trace_done,
  input  logic        trace_en,
  input  logic        secure,
  input  logic        cop_swbrk_req,
  output logic        armed,
  output logic        enter_st1,
  output logic        force_final,
  output logic        cpu_brk,
  output logic        cop_brk,
  output logic        bdm_sel,
  output logic [1:0]  bank_sel
);
  cfg_t             cfg;
  logic             session_end;
  logic [TGT_W-1:0] brk_q;

  dbgctl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
    .session_end(session_end), .armed(armed), .cfg(cfg),
    .enter_st1(enter_st1), .rdata(ctl_rdata)
  );

  dbgctl_trig u_trig (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
    .armed(armed), .secure(secure), .session_end(session_end),
    .force_final(force_final)
  );

  dbgctl_brk u_brk (
    .clk(clk), .rst_n(rst_n), .armed(armed), .cfg(cfg),
    .final_hit(final_hit), .trace_done(trace_done), .trace_en(trace_en),
    .cop_swbrk_req(cop_swbrk_req), .session_end(session_end), .brk_q(brk_q)
  );

  assign cpu_brk  = brk_q[TGT_CPU];
  assign cop_brk  = brk_q[TGT_COP];
  assign bdm_sel  = cfg.bdm;
  assign bank_sel = cfg.bank;
endmodule

// File: rtl/dbgctl_chk.sv
module dbgctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctl_rdata,
  input logic       secure,
  input logic       armed,
  input logic       enter_st1,
  input logic       force_final,
  input logic       cop_brk,
  input logic       bdm_sel,
  input logic [1:0] bank_sel
);
  // R2
  trig_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[6] == 1'b0);
  // R3
  enter_sets_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_st1 |-> armed);
  // R4
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> ($stable(bank_sel) && $stable(bdm_sel) && $stable(ctl_rdata[5:0])));
  // R7
  no_trig_disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !force_final);
  // R6
  no_trig_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    secure |=> !force_final);
  // R8
  cop_brk_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cop_brk |-> !armed);
  // R11
  pulses_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({enter_st1, force_final}));
endmodule

bind dbg_arm_ctrl dbgctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_rdata(ctl_rdata), .secure(secure),
  .armed(armed), .enter_st1(enter_st1), .force_final(force_final),
  .cop_brk(cop_brk), .bdm_sel(bdm_sel), .bank_sel(bank_sel)
);

// File: tb/dbg_arm_ctrl_bench.sv
module dbg_arm_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic       final_hit = 1'b0, trace_done = 1'b0, trace_en = 1'b0;
  logic       secure = 1'b0, cop_swbrk_req = 1'b0;
  logic       armed, enter_st1, force_final, cpu_brk, cop_brk, bdm_sel;
  logic [1:0] bank_sel;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_arm_ctrl u_dbg_arm_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .final_hit(final_hit), .trace_done(trace_done),
    .trace_en(trace_en), .secure(secure), .cop_swbrk_req(cop_swbrk_req),
    .armed(armed), .enter_st1(enter_st1), .force_final(force_final),
    .cpu_brk(cpu_brk), .cop_brk(cop_brk), .bdm_sel(bdm_sel), .bank_sel(bank_sel)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // apply inputs for one cycle; outputs are sampled 1 time unit after the edge
  task automatic step(input logic wr, input logic [7:0] wd, input logic fh,
                      input logic td, input logic te, input logic sec,
                      input logic swb);
    ctl_wr = wr; ctl_wdata = wd; final_hit = fh; trace_done = td;
    trace_en = te; secure = sec; cop_swbrk_req = swb;
    @(posedge clk); #1;
    ctl_wr = 1'b0; final_hit = 1'b0; trace_done = 1'b0; cop_swbrk_req = 1'b0;
  endtask

  task automatic wr_word(input logic [7:0] wd, input logic sec);
    step(1'b1, wd, 1'b0, 1'b0, 1'b0, sec, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 rdata", ctl_rdata, 0);
    chk("R1 outputs", {armed, enter_st1, force_final, cpu_brk, cop_brk, bdm_sel, bank_sel}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R2 R3 R7: sweep every value from disarmed
    for (int v = 0; v < 256; v++) begin
      logic [7:0] w;
      w = v[7:0];
      wr_word(w, 1'b0);
      chk("R2 rdata", ctl_rdata, int'(w & 8'hBF));
      chk("R2 bdm_sel", bdm_sel, w[4]);
      chk("R2 bank_sel", bank_sel, w[1:0]);
      chk("R3 enter_st1", enter_st1, w[7]);
      chk("R7 force_final", force_final, 0);
      if (w[7]) begin
        wr_word(8'h00, 1'b0);
        chk("R3 no pulse after", enter_st1, 0);
        chk("R4 disarm write", ctl_rdata, int'(w & 8'h3F));
      end
    end

    // R4 R5 R6: sweep every write against locked configurations
    for (int k = 0; k < 4; k++) begin
      logic [5:0] c;
      c = (k == 0) ? 6'h00 : (k == 1) ? 6'h15 : (k == 2) ? 6'h2A : 6'h3F;
      wr_word(8'h00, 1'b0);
      wr_word({2'b10, c}, 1'b0);
      for (int s = 0; s < 2; s++) begin
        for (int v = 0; v < 256; v++) begin
          logic [7:0] w;
          w = v[7:0];
          wr_word(w, s[0]);
          chk("R4 locked rdata", ctl_rdata, int'({w[7], 1'b0, c}));
          chk("R3 no re-enter", enter_st1, 0);
          if (s == 0) chk("R5 force_final", force_final, int'(w[7] & w[6]));
          else        chk("R6 secure block", force_final, 0);
          if (!w[7]) begin
            wr_word({2'b10, c}, 1'b0);
            chk("R3 re-arm pulse", enter_st1, 1);
          end
        end
      end
    end

    // R8 R9: session end per target code and trace mode
    for (int t = 0; t < 4; t++) begin
      for (int te = 0; te < 2; te++) begin
        logic [1:0] tg;
        tg = t[1:0];
        wr_word(8'h00, 1'b0);
        wr_word({2'b00, 2'b00, tg, 2'b00}, 1'b0);
        step(1'b0, 8'h00, 1'b1, 1'b0, te[0], 1'b0, 1'b0);
        chk("R8 disarmed final_hit", {cpu_brk, cop_brk}, 0);
        wr_word({2'b10, 2'b00, tg, 2'b00}, 1'b0);
        step(1'b0, 8'h00, 1'b1, 1'b0, te[0], 1'b0, 1'b0);
        if (te == 0) begin
          chk("R8 cpu_brk", cpu_brk, tg[1]);
          chk("R8 cop_brk", cop_brk, tg[0]);
          chk("R8 disarmed", armed, 0);
        end else begin
          chk("R9 no early brk", {cpu_brk, cop_brk}, 0);
          chk("R9 still armed", armed, 1);
          step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
          chk("R9 cpu_brk", cpu_brk, tg[1]);
          chk("R9 cop_brk", cop_brk, tg[0]);
          chk("R9 disarmed", armed, 0);
        end
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R8 pulse width", {cpu_brk, cop_brk}, 0);
      end
    end

    // R10: coprocessor request forwarding
    for (int e = 0; e < 2; e++) begin
      for (int t = 0; t < 4; t++) begin
        for (int a = 0; a < 2; a++) begin
          wr_word(8'h00, 1'b0);
          wr_word({a[0], 1'b0, e[0], 1'b0, t[1:0], 2'b00}, 1'b0);
          step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
          chk("R10 cpu_brk", cpu_brk, e);
          chk("R10 cop_brk", cop_brk, 0);
          chk("R10 arm kept", armed, a);
        end
      end
    end

    // R11: session end collides with a write
    wr_word(8'h00, 1'b0);
    wr_word(8'h8C, 1'b0);
    step(1'b1, 8'hCC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R11 disarmed", armed, 0);
    chk("R11 no pulses", {enter_st1, force_final}, 0);
    chk("R11 brk", {cpu_brk, cop_brk}, 3);
    wr_word(8'h80, 1'b0);
    step(1'b1, 8'h80, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R11 trace end wins", armed, 0);
    chk("R11 no enter", enter_st1, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule